// File: doc/BRIEF.md
# Policy-Selectable Set-Associative Word Cache

This block is a set-associative data cache for 32-bit word accesses. It sits between a processor-side request port and a backing-memory word port. Configuration inputs choose the write policy and the victim-selection scheme while the block runs. There are three write policies: write-through without allocation, write-through with allocation, and write-back. There are three victim schemes: pseudo-random, least-recently-used and least-frequently-used.

The block detects hits and misses. On a miss it fills the whole line, one word per memory beat, and it writes a dirty victim back before the fill starts. An inclusive address window, or a cleared enable input, sends an access straight to memory. Four counters record cache hits, cache misses, and every word read from or written to backing memory. Reset invalidates every line and zeroes the counters.

The processor raises `cpu_req` while `cpu_busy` is low. `cpu_busy` then stays high until the access ends. `cpu_done` pulses for one cycle at the end, with `cpu_rdata` valid during that pulse for a read. On the memory side, each beat holds `mem_req` and its address, data and direction until `mem_ready` is sampled high. Read data is taken from `mem_rdata` on that same edge.

Top module: `policy_cache`

## Requirements
- R1: After reset, all four counters read zero, `cpu_busy` is low, and every line is invalid, so the first access to any cached address is a miss.
- R2: A read hit returns the stored word, adds one to the hit counter, and makes no memory request.
- R3: A read miss fetches every word of the line in ascending word order at the line base address plus 4 times the word index. The memory-read counter rises by the words-per-line count, the miss counter rises by one, and the requested word is returned.
- R4: With `cfg_wpol` = 0 (write-through, no allocation), a write miss performs one memory write and no fill. The miss counter and the memory-write counter each rise by one, and a later read of that line still misses.
- R5: Under either write-through policy (`cfg_wpol` 0 or 1), a write hit updates the cached word and also issues one memory write, so the memory-write counter rises by one.
- R6: With `cfg_wpol` = 1 (write-through with allocation), a write miss fills the line, merges the word into it and writes the word to memory. A following read of that word hits.
- R7: With `cfg_wpol` = 2 or 3 (write-back), a write hit updates the line, marks it dirty and makes no memory access.
- R8: Evicting a dirty line writes all of its words to memory in ascending order at the line base address plus 4 times the word index, before the first fill read. The memory-write counter rises by the words-per-line count.
- R9: When an address lies inside the inclusive window `unc_lo`..`unc_hi`, or when `cfg_enable` is low, the access makes exactly one memory beat. That beat raises the memory-read or memory-write counter by one, and the hit and miss counters do not change.
- R10: With `cfg_repl` = 1 (LRU), when every way of the set is valid the victim is the way touched least recently. Both hits and fills count as touches.
- R11: With `cfg_repl` = 2 or 3 (LFU), a hit adds one to the way's saturating use count, and a fill restarts that count at zero. The victim is the valid way with the smallest count, and a tie goes to the lowest way index.
- R12: With `cfg_repl` = 0 (random), a miss in a full set replaces one way chosen by a free-running LFSR. An invalid way is always chosen before any valid way, under every scheme.
- R13: A memory request holds its address, data and direction stable until `mem_ready` is sampled high, and it is raised only while `cpu_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; invalidates lines, zeroes counters |
| cfg_enable | input | 1 | Cache enable; when low every access bypasses |
| cfg_wpol | input | 2 | Write policy: 0 WT no-alloc, 1 WT alloc, 2/3 write-back |
| cfg_repl | input | 2 | Victim scheme: 0 random, 1 LRU, 2/3 LFU |
| unc_lo | input | 32 | Lowest byte address of the uncached window |
| unc_hi | input | 32 | Highest byte address of the uncached window |
| cpu_req | input | 1 | Access request, taken while cpu_busy is low |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_done |
| cpu_busy | output | 1 | Access in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat direction, 1 write |
| mem_addr | output | 32 | Memory word byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, taken with mem_ready |
| mem_ready | input | 1 | Memory beat completes at this edge |
| hit_cnt | output | 32 | Cache hit count |
| miss_cnt | output | 32 | Cache miss count |
| mem_rd_cnt | output | 32 | Words read from memory |
| mem_wr_cnt | output | 32 | Words written to memory |

## Verification
Some properties are checked on every cycle: a request is held stable until memory accepts it, memory is requested only while busy, and the read and write counters move only on a completed beat of the matching direction. The hit and miss counters also advance by at most one, and never on the same edge. The scenarios show the rest: which way each scheme evicts, the write-back-then-fill order and its data, allocation versus no allocation on a write miss, the LFU count restarting on refill, and bypass under the window and under disable.

// File: rtl/pcache_pkg.sv
package pcache_pkg;
    localparam logic [1:0] WPOL_WT_NA = 2'd0;
    localparam logic [1:0] WPOL_WT_AL = 2'd1;
    localparam logic [1:0] RPL_RAND   = 2'd0;
    localparam logic [1:0] RPL_LRU    = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOOK, ST_EVICT, ST_FILL, ST_POST, ST_WTHRU, ST_BYPASS
    } pc_state_e;
endpackage

// File: rtl/pcache_lfsr.sv
module pcache_lfsr #(
    parameter int W     = 16,
    parameter int OUT_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[W-2:0], sr_q[W-1] ^ sr_q[W-2] ^ sr_q[W-4] ^ sr_q[3]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= W'(1);
        else        sr_q <= sr_d;
    end

    assign rnd = sr_q[OUT_W-1:0];
endmodule

// File: rtl/pcache_tagcmp.sv
module pcache_tagcmp #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 27,
    localparam int IW   = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            tag,
    output logic                        hit,
    output logic [IW-1:0]               hit_way
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign match[g] = vld[g] && (tags[g] == tag);
    end

    always_comb begin
        hit_way = '0;
        for (int k = 0; k < WAYS; k++) begin
            if (match[k]) hit_way = IW'(k);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/pcache_victim.sv
module pcache_victim #(
    parameter int WAYS  = 2,
    parameter int LFU_W = 4,
    localparam int IW   = $clog2(WAYS)
) (
    input  logic [1:0]                  repl,
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][IW-1:0]     age,
    input  logic [WAYS-1:0][LFU_W-1:0]  freq,
    input  logic [IW-1:0]               rnd,
    output logic [IW-1:0]               way
);
    import pcache_pkg::*;

    logic             found;
    logic [LFU_W-1:0] best;

    always_comb begin
        way   = '0;
        found = 1'b0;
        best  = freq[0];
        for (int k = 0; k < WAYS; k++) begin
            if (!vld[k] && !found) begin
                way   = IW'(k);
                found = 1'b1;
            end
        end
        if (!found) begin
            if (repl == RPL_RAND) begin
                way = rnd;
            end else if (repl == RPL_LRU) begin
                for (int k = 0; k < WAYS; k++) begin
                    if (age[k] == IW'(WAYS - 1)) way = IW'(k);
                end
            end else begin
                for (int k = 1; k < WAYS; k++) begin
                    if (freq[k] < best) begin
                        best = freq[k];
                        way  = IW'(k);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/policy_cache.sv
module policy_cache #(
    parameter int WAYS  = 2,
    parameter int SETS  = 4,
    parameter int WORDS = 2,
    parameter int LFU_W = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [1:0]       cfg_wpol,
    input  logic [1:0]       cfg_repl,
    input  logic [31:0]      unc_lo,
    input  logic [31:0]      unc_hi,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [31:0]      cpu_addr,
    input  logic [31:0]      cpu_wdata,
    output logic [31:0]      cpu_rdata,
    output logic             cpu_busy,
    output logic             cpu_done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ready,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] miss_cnt,
    output logic [CNT_W-1:0] mem_rd_cnt,
    output logic [CNT_W-1:0] mem_wr_cnt
);
    import pcache_pkg::*;

    localparam int IW    = $clog2(WAYS);
    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = 30 - OFF_W - IDX_W;

    typedef logic [WAYS-1:0][IW-1:0] age_row_t;

    typedef struct packed {
        pc_state_e                                     st;
        logic                                          we;
        logic [31:0]                                   addr;
        logic [31:0]                                   wdata;
        logic [IW-1:0]                                 way;
        logic [OFF_W-1:0]                              beat;
        logic                                          done;
        logic [31:0]                                   rdata;
        logic [SETS-1:0][WAYS-1:0]                     vld;
        logic [SETS-1:0][WAYS-1:0]                     dty;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]          tag;
        logic [SETS-1:0][WAYS-1:0][WORDS-1:0][31:0]    dat;
        logic [SETS-1:0]                               age_pad;
        age_row_t [SETS-1:0]                           age;
        logic [SETS-1:0][WAYS-1:0][LFU_W-1:0]          freq;
        logic [CNT_W-1:0]                              n_hit;
        logic [CNT_W-1:0]                              n_miss;
        logic [CNT_W-1:0]                              n_rd;
        logic [CNT_W-1:0]                              n_wr;
    } cache_st_t;

    cache_st_t s_d, s_q;

    // Move way w to most recent; ways younger than it age by one.
    function automatic age_row_t lru_touch(input age_row_t r, input logic [IW-1:0] w);
        age_row_t o;
        o = r;
        for (int k = 0; k < WAYS; k++) begin
            if (IW'(k) == w)      o[k] = '0;
            else if (r[k] < r[w]) o[k] = r[k] + IW'(1);
        end
        return o;
    endfunction

    logic [IDX_W-1:0] set_i;
    logic [OFF_W-1:0] wrd_i;
    logic [TAG_W-1:0] tag_i;
    logic             bypass;
    logic             is_wb;
    logic             last_beat;
    logic             hit;
    logic [IW-1:0]    hit_way;
    logic [IW-1:0]    vict_way;
    logic [IW-1:0]    rnd;

    assign set_i     = s_q.addr[2+OFF_W +: IDX_W];
    assign wrd_i     = s_q.addr[2 +: OFF_W];
    assign tag_i     = s_q.addr[31 -: TAG_W];
    assign bypass    = !cfg_enable || (s_q.addr >= unc_lo && s_q.addr <= unc_hi);
    assign is_wb     = cfg_wpol[1];
    assign last_beat = (s_q.beat == OFF_W'(WORDS - 1));

    pcache_lfsr #(.W(16), .OUT_W(IW)) u_lfsr (
        .clk (clk),
        .rst_n (rst_n),
        .rnd (rnd)
    );

    pcache_tagcmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
        .vld     (s_q.vld[set_i]),
        .tags    (s_q.tag[set_i]),
        .tag     (tag_i),
        .hit     (hit),
        .hit_way (hit_way)
    );

    pcache_victim #(.WAYS(WAYS), .LFU_W(LFU_W)) u_vic (
        .repl (cfg_repl),
        .vld  (s_q.vld[set_i]),
        .age  (s_q.age[set_i]),
        .freq (s_q.freq[set_i]),
        .rnd  (rnd),
        .way  (vict_way)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    s_d.addr  = cpu_addr;
                    s_d.we    = cpu_we;
                    s_d.wdata = cpu_wdata;
                    s_d.st    = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (bypass) begin
                    s_d.st = ST_BYPASS;
                end else if (hit) begin
                    s_d.n_hit       = s_q.n_hit + CNT_W'(1);
                    s_d.way         = hit_way;
                    s_d.age[set_i]  = lru_touch(s_q.age[set_i], hit_way);
                    if (s_q.freq[set_i][hit_way] != '1)
                        s_d.freq[set_i][hit_way] = s_q.freq[set_i][hit_way] + LFU_W'(1);
                    if (!s_q.we) begin
                        s_d.rdata = s_q.dat[set_i][hit_way][wrd_i];
                        s_d.done  = 1'b1;
                        s_d.st    = ST_IDLE;
                    end else begin
                        s_d.dat[set_i][hit_way][wrd_i] = s_q.wdata;
                        if (is_wb) begin
                            s_d.dty[set_i][hit_way] = 1'b1;
                            s_d.done                = 1'b1;
                            s_d.st                  = ST_IDLE;
                        end else begin
                            s_d.st = ST_WTHRU;
                        end
                    end
                end else begin
                    s_d.n_miss = s_q.n_miss + CNT_W'(1);
                    if (s_q.we && cfg_wpol == WPOL_WT_NA) begin
                        s_d.st = ST_WTHRU;
                    end else begin
                        s_d.way  = vict_way;
                        s_d.beat = '0;
                        if (s_q.vld[set_i][vict_way] && s_q.dty[set_i][vict_way])
                            s_d.st = ST_EVICT;
                        else
                            s_d.st = ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                if (mem_ready) begin
                    s_d.n_wr = s_q.n_wr + CNT_W'(1);
                    if (last_beat) begin
                        s_d.vld[set_i][s_q.way] = 1'b0;
                        s_d.dty[set_i][s_q.way] = 1'b0;
                        s_d.beat                = '0;
                        s_d.st                  = ST_FILL;
                    end else begin
                        s_d.beat = s_q.beat + OFF_W'(1);
                    end
                end
            end
            ST_FILL: begin
                if (mem_ready) begin
                    s_d.dat[set_i][s_q.way][s_q.beat] = mem_rdata;
                    s_d.n_rd = s_q.n_rd + CNT_W'(1);
                    if (last_beat) begin
                        s_d.vld[set_i][s_q.way]  = 1'b1;
                        s_d.dty[set_i][s_q.way]  = 1'b0;
                        s_d.tag[set_i][s_q.way]  = tag_i;
                        s_d.freq[set_i][s_q.way] = '0;
                        s_d.age[set_i]           = lru_touch(s_q.age[set_i], s_q.way);
                        s_d.st                   = ST_POST;
                    end else begin
                        s_d.beat = s_q.beat + OFF_W'(1);
                    end
                end
            end
            ST_POST: begin
                if (!s_q.we) begin
                    s_d.rdata = s_q.dat[set_i][s_q.way][wrd_i];
                    s_d.done  = 1'b1;
                    s_d.st    = ST_IDLE;
                end else begin
                    s_d.dat[set_i][s_q.way][wrd_i] = s_q.wdata;
                    if (is_wb) begin
                        s_d.dty[set_i][s_q.way] = 1'b1;
                        s_d.done                = 1'b1;
                        s_d.st                  = ST_IDLE;
                    end else begin
                        s_d.st = ST_WTHRU;
                    end
                end
            end
            ST_WTHRU: begin
                if (mem_ready) begin
                    s_d.n_wr = s_q.n_wr + CNT_W'(1);
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end
            end
            ST_BYPASS: begin
                if (mem_ready) begin
                    if (s_q.we) begin
                        s_d.n_wr = s_q.n_wr + CNT_W'(1);
                    end else begin
                        s_d.n_rd  = s_q.n_rd + CNT_W'(1);
                        s_d.rdata = mem_rdata;
                    end
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    s_q.age[s][w] <= IW'(w);
                end
            end
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {s_q.addr[31:2], 2'b00};
        mem_wdata = s_q.wdata;
        unique case (s_q.st)
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {s_q.tag[set_i][s_q.way], set_i, s_q.beat, 2'b00};
                mem_wdata = s_q.dat[set_i][s_q.way][s_q.beat];
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {tag_i, set_i, s_q.beat, 2'b00};
            end
            ST_WTHRU: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_BYPASS: begin
                mem_req = 1'b1;
                mem_we  = s_q.we;
            end
            default: ;
        endcase
    end

    assign cpu_busy   = (s_q.st != ST_IDLE);
    assign cpu_done   = s_q.done;
    assign cpu_rdata  = s_q.rdata;
    assign hit_cnt    = s_q.n_hit;
    assign miss_cnt   = s_q.n_miss;
    assign mem_rd_cnt = s_q.n_rd;
    assign mem_wr_cnt = s_q.n_wr;
endmodule

// File: rtl/pcache_chk.sv
module pcache_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_busy,
    input logic             cpu_done,
    input logic             mem_req,
    input logic             mem_we,
    input logic [31:0]      mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_ready,
    input logic [CNT_W-1:0] hit_cnt,
    input logic [CNT_W-1:0] miss_cnt,
    input logic [CNT_W-1:0] mem_rd_cnt,
    input logic [CNT_W-1:0] mem_wr_cnt
);
    p_req_in_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_busy);

    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_rd_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_cnt != $past(mem_rd_cnt)) |-> ($past(mem_req && mem_ready && !mem_we) && mem_rd_cnt == $past(mem_rd_cnt) + CNT_W'(1)));

    p_wr_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_cnt != $past(mem_wr_cnt)) |-> ($past(mem_req && mem_ready && mem_we) && mem_wr_cnt == $past(mem_wr_cnt) + CNT_W'(1)));

    p_hit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cnt != $past(hit_cnt)) |-> (hit_cnt == $past(hit_cnt) + CNT_W'(1) && miss_cnt == $past(miss_cnt)));

    p_miss_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_cnt != $past(miss_cnt)) |-> (miss_cnt == $past(miss_cnt) + CNT_W'(1)));

    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> (!cpu_busy && $past(cpu_busy)));
endmodule

bind policy_cache pcache_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_busy   (cpu_busy),
    .cpu_done   (cpu_done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .hit_cnt    (hit_cnt),
    .miss_cnt   (miss_cnt),
    .mem_rd_cnt (mem_rd_cnt),
    .mem_wr_cnt (mem_wr_cnt)
);

// File: tb/policy_cache_tb.sv
module policy_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1;
    logic [1:0]  cfg_wpol = 2'd2;
    logic [1:0]  cfg_repl = 2'd1;
    logic [31:0] unc_lo = 32'h200;
    logic [31:0] unc_hi = 32'h2FF;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_busy, cpu_done;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [31:0] hit_cnt, miss_cnt, mem_rd_cnt, mem_wr_cnt;

    always #4 clk = ~clk;

    policy_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_wpol(cfg_wpol),
        .cfg_repl(cfg_repl), .unc_lo(unc_lo), .unc_hi(unc_hi),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .mem_rd_cnt(mem_rd_cnt), .mem_wr_cnt(mem_wr_cnt)
    );

    // Backing memory: ready on alternate cycles, log of completed beats
    logic [31:0] mem [256];
    logic        tog = 1'b0;
    logic [31:0] cap_a, cap_d;
    logic        cap_we = 1'b0;
    logic [31:0] log_a [16];
    logic [31:0] log_d [16];
    logic        log_w [16];
    int          log_n = 0;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 | (i << 2);
    end

    always @(negedge clk) begin
        if (mem_ready) begin
            if (cap_we) mem[cap_a[9:2]] = cap_d;
            if (log_n < 16) begin
                log_a[log_n] = cap_a;
                log_d[log_n] = cap_d;
                log_w[log_n] = cap_we;
            end
            log_n = log_n + 1;
        end
        tog = ~tog;
        mem_ready = mem_req && tog;
        if (mem_ready) begin
            cap_a = mem_addr;
            cap_d = mem_wdata;
            cap_we = mem_we;
            mem_rdata = mem[mem_addr[9:2]];
        end
    end

    int n_tests = 0;
    int n_fail = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    logic [31:0] b_hit, b_miss, b_rd, b_wr;

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        log_n = 0;
    endtask

    task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] rd);
        b_hit = hit_cnt; b_miss = miss_cnt; b_rd = mem_rd_cnt; b_wr = mem_wr_cnt;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_done) @(negedge clk);
        rd = cpu_rdata;
    endtask

    task automatic deltas(input string req, input int dh, input int dm, input int drd, input int dwr);
        check({req, " hit delta"},  hit_cnt - b_hit,     32'(dh));
        check({req, " miss delta"}, miss_cnt - b_miss,   32'(dm));
        check({req, " mrd delta"},  mem_rd_cnt - b_rd,   32'(drd));
        check({req, " mwr delta"},  mem_wr_cnt - b_wr,   32'(dwr));
    endtask

    typedef struct packed {
        logic        en;
        logic [1:0]  wpol;
        logic [1:0]  repl;
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  dh;
        logic [3:0]  dm;
        logic [3:0]  drd;
        logic [3:0]  dwr;
    } vec_t;

    // Write-back + LRU, 2 ways, 4 sets, 2 words per line; set 0 = 0x00,0x20,0x40,0x60
    localparam vec_t TBL [14] = '{
        '{1'b1, 2'd2, 2'd1, 1'b0, 32'h000, 32'h0,        32'h1000_0000, 4'd0, 4'd1, 4'd2, 4'd0}, // R3 fill
        '{1'b1, 2'd2, 2'd1, 1'b0, 32'h004, 32'h0,        32'h1000_0004, 4'd1, 4'd0, 4'd0, 4'd0}, // R2 hit
        '{1'b1, 2'd2, 2'd1, 1'b1, 32'h004, 32'hDEAD0001, 32'h0,         4'd1, 4'd0, 4'd0, 4'd0}, // R7 no mem write
        '{1'b1, 2'd2, 2'd1, 1'b0, 32'h004, 32'h0,        32'hDEAD0001,  4'd1, 4'd0, 4'd0, 4'd0}, // R7 line updated
        '{1'b1, 2'd2, 2'd1, 1'b0, 32'h020, 32'h0,        32'h1000_0020, 4'd0, 4'd1, 4'd2, 4'd0}, // R12 invalid way first
        '{1'b1, 2'd2, 2'd1, 1'b0, 32'h000, 32'h0,        32'h1000_0000, 4'd1, 4'd0, 4'd0, 4'd0}, // R10 touch way 0
        '{1'b1, 2'd2, 2'd1, 1'b0, 32'h040, 32'h0,        32'h1000_0040, 4'd0, 4'd1, 4'd2, 4'd0}, // R10 evict clean 0x20
        '{1'b1, 2'd2, 2'd1, 1'b0, 32'h000, 32'h0,        32'h1000_0000, 4'd1, 4'd0, 4'd0, 4'd0}, // R10 0x00 kept
        '{1'b1, 2'd2, 2'd1, 1'b0, 32'h060, 32'h0,        32'h1000_0060, 4'd0, 4'd1, 4'd2, 4'd0}, // R10 evict 0x40
        '{1'b1, 2'd2, 2'd1, 1'b0, 32'h020, 32'h0,        32'h1000_0020, 4'd0, 4'd1, 4'd2, 4'd2}, // R8 dirty 0x00 out
        '{1'b1, 2'd2, 2'd1, 1'b0, 32'h204, 32'h0,        32'h1000_0204, 4'd0, 4'd0, 4'd1, 4'd0}, // R9 window read
        '{1'b1, 2'd2, 2'd1, 1'b1, 32'h200, 32'h55,       32'h0,         4'd0, 4'd0, 4'd0, 4'd1}, // R9 window write
        '{1'b1, 2'd2, 2'd1, 1'b0, 32'h200, 32'h0,        32'h0000_0055, 4'd0, 4'd0, 4'd1, 4'd0}, // R9 reread
        '{1'b0, 2'd2, 2'd1, 1'b0, 32'h004, 32'h0,        32'hDEAD0001,  4'd0, 4'd0, 4'd1, 4'd0}  // R9 disabled, R8 data
    };

    initial begin
        logic [31:0] rd;
        apply_reset();
        // R1 reset state
        check("R1 hit_cnt",  hit_cnt,    32'h0);
        check("R1 miss_cnt", miss_cnt,   32'h0);
        check("R1 mrd_cnt",  mem_rd_cnt, 32'h0);
        check("R1 mwr_cnt",  mem_wr_cnt, 32'h0);
        check("R1 busy",     {31'h0, cpu_busy}, 32'h0);

        // R13 busy rises after accept
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'h100;
        @(negedge clk);
        cpu_req = 1'b0;
        check("R13 busy after accept", {31'h0, cpu_busy}, 32'h1);
        while (!cpu_done) @(negedge clk);
        check("R3 read miss data", cpu_rdata, 32'h1000_0100);

        apply_reset();
        for (int i = 0; i < 14; i++) begin
            cfg_enable = TBL[i].en; cfg_wpol = TBL[i].wpol; cfg_repl = TBL[i].repl;
            acc(TBL[i].we, TBL[i].addr, TBL[i].wdata, rd);
            if (!TBL[i].we) check($sformatf("table row %0d rdata", i), rd, TBL[i].exp);
            deltas($sformatf("table row %0d", i), int'(TBL[i].dh), int'(TBL[i].dm),
                   int'(TBL[i].drd), int'(TBL[i].dwr));
        end
        cfg_enable = 1'b1;

        // R1 reset invalidates lines
        apply_reset();
        acc(1'b0, 32'h020, 32'h0, rd);
        deltas("R1 miss after reset", 0, 1, 2, 0);

        // R4 write-through no-allocate
        apply_reset();
        cfg_wpol = 2'd0; cfg_repl = 2'd1;
        acc(1'b1, 32'h008, 32'h77, rd);
        deltas("R4 write miss", 0, 1, 0, 1);
        acc(1'b0, 32'h008, 32'h0, rd);
        check("R4 read after", rd, 32'h77);
        deltas("R4 still miss", 0, 1, 2, 0);
        // R5 write-through hit
        acc(1'b1, 32'h008, 32'h88, rd);
        deltas("R5 write hit", 1, 0, 0, 1);
        acc(1'b0, 32'h008, 32'h0, rd);
        check("R5 cached word", rd, 32'h88);
        // R6 write-through allocate
        cfg_wpol = 2'd1;
        acc(1'b1, 32'h010, 32'h99, rd);
        deltas("R6 write miss alloc", 0, 1, 2, 1);
        acc(1'b0, 32'h010, 32'h0, rd);
        check("R6 read hit data", rd, 32'h99);
        deltas("R6 read hit", 1, 0, 0, 0);
        cfg_enable = 1'b0;
        acc(1'b0, 32'h010, 32'h0, rd);
        check("R6 memory written", rd, 32'h99);
        cfg_enable = 1'b1;

        // R8 eviction order
        apply_reset();
        cfg_wpol = 2'd2; cfg_repl = 2'd1;
        acc(1'b1, 32'h000, 32'h1, rd);
        acc(1'b1, 32'h020, 32'h2, rd);
        log_n = 0;
        acc(1'b0, 32'h040, 32'h0, rd);
        check("R8 beat count", 32'(log_n), 32'd4);
        check("R8 beat0 addr", log_a[0], 32'h000);
        check("R8 beat0 dir",  {31'h0, log_w[0]}, 32'h1);
        check("R8 beat0 data", log_d[0], 32'h1);
        check("R8 beat1 addr", log_a[1], 32'h004);
        check("R8 beat1 dir",  {31'h0, log_w[1]}, 32'h1);
        check("R3 fill beat0 addr", log_a[2], 32'h040);
        check("R3 fill beat0 dir",  {31'h0, log_w[2]}, 32'h0);
        check("R3 fill beat1 addr", log_a[3], 32'h044);

        // R11 LFU
        apply_reset();
        cfg_wpol = 2'd1; cfg_repl = 2'd2;
        acc(1'b0, 32'h000, 32'h0, rd);
        acc(1'b0, 32'h020, 32'h0, rd);
        for (int k = 0; k < 3; k++) acc(1'b0, 32'h020, 32'h0, rd);
        acc(1'b0, 32'h000, 32'h0, rd);
        acc(1'b0, 32'h040, 32'h0, rd);          // evicts way0 (1 < 3)
        acc(1'b0, 32'h020, 32'h0, rd);
        deltas("R11 frequent line kept", 1, 0, 0, 0);
        for (int k = 0; k < 5; k++) acc(1'b0, 32'h040, 32'h0, rd);
        acc(1'b0, 32'h060, 32'h0, rd);          // evicts way1 (4 < 5), count restarts
        acc(1'b0, 32'h060, 32'h0, rd);
        acc(1'b0, 32'h000, 32'h0, rd);          // evicts way1 (1 < 5)
        acc(1'b0, 32'h040, 32'h0, rd);
        deltas("R11 refill count restarted", 1, 0, 0, 0);

        // R12 random
        apply_reset();
        cfg_repl = 2'd0;
        acc(1'b0, 32'h000, 32'h0, rd);
        acc(1'b0, 32'h020, 32'h0, rd);
        acc(1'b0, 32'h040, 32'h0, rd);
        deltas("R12 one replacement", 0, 1, 2, 0);
        acc(1'b0, 32'h040, 32'h0, rd);
        check("R12 new line data", rd, 32'h1000_0040);
        deltas("R12 new line hits", 1, 0, 0, 0);

        report();
    end
endmodule